// File: doc/BRIEF.md
# SPI Master Controller with Contention Detection

This block is a register-programmed serial master. Software writes a word into a one-entry holding register. Once the shift engine is free, the block moves that word into the engine and sends it on the serial data output. In the same transfer it captures the serial data input into a receive word. The serial clock is made from the system clock by a programmable divider. Clock idle level, sampling phase, bit order and word length (8, 16 or 32 bits) are set in a control register. A selection register picks which of several active-low chip-select lines frames the word.

The block also watches an external select input, which another master drives when it wants the bus. If that input falls while a word is being shifted, the transfer is aborted, a fault flag is raised and the block gives up master operation. If it falls while the block is idle, the block quietly drops the master bit and raises no flag. The completion and fault flags stay set until software clears them by writing ones to the status register.

Register map (3-bit address, 32-bit data):
- 0 control: bit0 enable, bit1 master, bit2 clock idle level, bit3 phase, bit4 LSB-first, bits 6:5 width.
- 1 divider.
- 2 chip-select index.
- 3 data: a write fills the holding register; a read returns the received word.
- 4 status: bit0 done, bit1 fault, bit2 busy, bit3 holding full.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset every register reads zero, all chip selects are high (inactive) and the serial clock is low.
- R2: A data write is discarded unless control bit0 (enable) and bit1 (master) are both 1. No chip select is asserted, and setting both bits later starts no transfer.
- R3: While no transfer runs, the serial clock rests at the level of control bit2.
- R4: Each half period of the serial clock lasts divider+1 system clock cycles.
- R5: With control bit3 at 0, input data is sampled on odd (leading) clock edges and output data changes on even edges. With bit3 at 1, input data is sampled on even edges and output data changes on odd edges. Each word takes exactly two edges per bit.
- R6: When control bit4 is 1 the word is sent and received least significant bit first; when it is 0, most significant bit first.
- R7: Control bits 6:5 set the word length: 0 gives 8 bits, 1 gives 16, and 2 or 3 give 32. Bits of the written word above that length are not sent. The received word reads back right-aligned with zeros above it.
- R8: Exactly the chip-select line whose number is in the selection register goes low for the whole word. It is released divider+1 system cycles after the last clock edge.
- R9: Status bit0 goes to 1 when a word completes, and the received word is then readable at address 3.
- R10: A word written while a transfer runs sets status bit3. It is sent right after the current word ends.
- R11: If the select input is low (after two synchronizing stages) while a transfer runs, the transfer is aborted and the chip selects are released. Status bit1 is set, status bit0 stays 0 and control bit1 is cleared.
- R12: If the select input is low while enabled as master and idle, control bit1 is cleared and status bit1 stays 0.
- R13: Writing 1 to status bit0 or bit1 clears that flag. Writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_in_n | input | 1 | Contention select input, active low |
| cs_n_o | output | NSS | Chip selects, active low, one-hot |

## Verification
The bench drives a slave model that follows the edge rules of the requirements. It runs all four clock modes with both bit orders and all three word lengths. A written word with high bits set checks that only the selected length is sent. A design that swapped sample and launch edges would return a word shifted by one bit. One that ignored the length would send or clock stray upper bits. The bench measures the divider timing and the chip-select release delay in system cycles, which catches an off-by-one divider. It also queues a second word mid-transfer, which catches a lost holding register. The two contention cases are exercised separately. A design that flagged a fault while idle, or kept shifting after contention, shows the wrong status bits or a chip select still asserted.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;
  localparam int MAXW = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_TAIL} eng_st_e;

  typedef struct packed {
    logic [1:0] wsel;
    logic       lsb_first;
    logic       cpha;
    logic       cpol;
    logic       master;
    logic       en;
  } ctrl_t;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd1;
  localparam logic [2:0] A_SEL  = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_STAT = 3'd4;

  function automatic int unsigned word_bits(logic [1:0] w);
    case (w)
      2'd0:    return 8;
      2'd1:    return 16;
      default: return 32;
    endcase
  endfunction
endpackage

// File: rtl/spi_host_presc.sv
module spi_host_presc #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [DIVW-1:0] div,
  output logic            tick
);
  logic [DIVW-1:0] cnt_q, cnt_d;

  assign tick = run && (cnt_q == div);

  always_comb begin
    if (!run)      cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_host_shift.sv
module spi_host_shift
  import spi_host_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NSS  = 4,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ctrl_t           ctrl,
  input  logic [SELW-1:0] sel,
  input  logic [DW-1:0]   hold,
  input  logic            hold_full,
  input  logic            abort,
  input  logic            miso,
  input  logic            tick,
  output logic            busy,
  output logic            load,
  output logic            done_evt,
  output logic            sck,
  output logic            mosi,
  output logic [NSS-1:0]  cs_n,
  output logic [DW-1:0]   rx_word
);
  localparam int EW = $clog2(2 * DW + 1);
  localparam int IW = $clog2(DW);

  eng_st_e         st_q, st_d;
  logic [EW-1:0]   edge_q, edge_d;
  logic            sck_q, sck_d;
  logic [DW-1:0]   tx_q, tx_d, rx_q, rx_d;
  logic [SELW-1:0] csel_q, csel_d;

  logic [EW-1:0] nbits, last_edge;
  logic [IW-1:0] top_i;
  logic [DW-1:0] mask;
  logic          go, lead, samp;

  assign nbits     = EW'(word_bits(ctrl.wsel));
  assign last_edge = EW'(nbits << 1);
  assign top_i     = IW'(nbits - 1'b1);
  assign mask      = DW'((64'd1 << nbits) - 64'd1);
  assign go        = hold_full && ctrl.en && ctrl.master;
  assign lead      = !edge_q[0];
  assign samp      = lead ^ ctrl.cpha;

  always_comb begin
    st_d     = st_q;
    edge_d   = edge_q;
    sck_d    = sck_q;
    tx_d     = tx_q;
    rx_d     = rx_q;
    csel_d   = csel_q;
    load     = 1'b0;
    done_evt = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        sck_d = ctrl.cpol;
        if (go && !abort) begin
          load   = 1'b1;
          st_d   = ST_SHIFT;
          edge_d = '0;
          tx_d   = hold;
          rx_d   = '0;
          csel_d = sel;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          sck_d  = ~sck_q;
          edge_d = edge_q + 1'b1;
          if (samp) begin
            if (ctrl.lsb_first) begin
              rx_d        = rx_q >> 1;
              rx_d[top_i] = miso;
            end else begin
              rx_d = {rx_q[DW-2:0], miso};
            end
          end else if (edge_q != '0) begin
            tx_d = ctrl.lsb_first ? (tx_q >> 1) : (tx_q << 1);
          end
          if (edge_d == last_edge) st_d = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (tick) begin
          st_d     = ST_IDLE;
          done_evt = 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d     = ST_IDLE;
      sck_d    = ctrl.cpol;
      load     = 1'b0;
      done_evt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      edge_q <= '0;
      sck_q  <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      csel_q <= '0;
    end else begin
      st_q   <= st_d;
      edge_q <= edge_d;
      sck_q  <= sck_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
      csel_q <= csel_d;
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign sck     = sck_q;
  assign mosi    = ctrl.lsb_first ? tx_q[0] : tx_q[top_i];
  assign cs_n    = busy ? ~(NSS'(1) << csel_q) : '1;
  assign rx_word = rx_q & mask;
endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
  import spi_host_pkg::*;
#(
  parameter int DW   = 32,
  parameter int DIVW = 8,
  parameter int SELW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [2:0]      addr,
  input  logic [31:0]     wdata,
  output logic [31:0]     rdata,
  input  logic            busy,
  input  logic            load,
  input  logic            done_evt,
  input  logic            ss_low,
  input  logic [DW-1:0]   rx_word,
  output ctrl_t           ctrl,
  output logic [DIVW-1:0] div,
  output logic [SELW-1:0] sel,
  output logic [DW-1:0]   hold,
  output logic            hold_full,
  output logic            modf_evt,
  output logic            modf,
  output logic            done
);
  ctrl_t           ctrl_q, ctrl_d;
  logic [DIVW-1:0] div_q, div_d;
  logic [SELW-1:0] sel_q, sel_d;
  logic [DW-1:0]   hold_q, hold_d, rx_q, rx_d;
  logic            full_q, full_d, modf_q, modf_d, done_q, done_d;
  logic            contend;

  assign contend  = ctrl_q.en && ctrl_q.master && ss_low;
  assign modf_evt = contend && busy;

  always_comb begin
    ctrl_d = ctrl_q;
    div_d  = div_q;
    sel_d  = sel_q;
    hold_d = hold_q;
    full_d = full_q;
    rx_d   = rx_q;
    modf_d = modf_q;
    done_d = done_q;
    if (we) begin
      unique case (addr)
        A_CTRL: ctrl_d = ctrl_t'(wdata[6:0]);
        A_DIV:  div_d  = wdata[DIVW-1:0];
        A_SEL:  sel_d  = wdata[SELW-1:0];
        A_STAT: begin
          if (wdata[0]) done_d = 1'b0;
          if (wdata[1]) modf_d = 1'b0;
        end
        default: ;
      endcase
    end
    if (load) full_d = 1'b0;
    if (we && addr == A_DATA && ctrl_q.en && ctrl_q.master) begin
      hold_d = wdata[DW-1:0];
      full_d = 1'b1;
    end
    if (!ctrl_q.en || !ctrl_q.master || contend) full_d = 1'b0;
    if (contend) ctrl_d.master = 1'b0;
    if (modf_evt) modf_d = 1'b1;
    if (done_evt) begin
      done_d = 1'b1;
      rx_d   = rx_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      sel_q  <= '0;
      hold_q <= '0;
      full_q <= 1'b0;
      rx_q   <= '0;
      modf_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      div_q  <= div_d;
      sel_q  <= sel_d;
      hold_q <= hold_d;
      full_q <= full_d;
      rx_q   <= rx_d;
      modf_q <= modf_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    unique case (addr)
      A_CTRL:  rdata = 32'(ctrl_q);
      A_DIV:   rdata = 32'(div_q);
      A_SEL:   rdata = 32'(sel_q);
      A_DATA:  rdata = 32'(rx_q);
      A_STAT:  rdata = {28'd0, full_q, busy, modf_q, done_q};
      default: rdata = '0;
    endcase
  end

  assign ctrl      = ctrl_q;
  assign div       = div_q;
  assign sel       = sel_q;
  assign hold      = hold_q;
  assign hold_full = full_q;
  assign modf      = modf_q;
  assign done      = done_q;
endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
  import spi_host_pkg::*;
#(
  parameter int NSS  = 4,
  parameter int DIVW = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [2:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           sck_o,
  output logic           mosi_o,
  input  logic           miso_i,
  input  logic           ss_in_n,
  output logic [NSS-1:0] cs_n_o
);
  localparam int DW   = MAXW;
  localparam int SELW = (NSS > 1) ? $clog2(NSS) : 1;

  logic rst_m, rst_q;
  logic ss_m, ss_s, ss_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_q <= rst_m;
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ss_m <= 1'b1;
      ss_s <= 1'b1;
    end else begin
      ss_m <= ss_in_n;
      ss_s <= ss_m;
    end
  end
  assign ss_low = !ss_s;

  ctrl_t           ctrl;
  logic [DIVW-1:0] div;
  logic [SELW-1:0] sel;
  logic [DW-1:0]   hold, rx_word;
  logic            hold_full, modf_evt, modf_q, done_q;
  logic            busy, load, done_evt, tick, abort;

  assign abort = modf_evt || !ctrl.en || !ctrl.master;

  spi_host_regs #(.DW(DW), .DIVW(DIVW), .SELW(SELW)) u_regs (
    .clk(clk), .rst_n(rst_q), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .busy(busy), .load(load), .done_evt(done_evt),
    .ss_low(ss_low), .rx_word(rx_word), .ctrl(ctrl), .div(div), .sel(sel),
    .hold(hold), .hold_full(hold_full), .modf_evt(modf_evt), .modf(modf_q),
    .done(done_q)
  );

  spi_host_presc #(.DIVW(DIVW)) u_presc (
    .clk(clk), .rst_n(rst_q), .run(busy), .div(div), .tick(tick)
  );

  spi_host_shift #(.DW(DW), .NSS(NSS), .SELW(SELW)) u_shift (
    .clk(clk), .rst_n(rst_q), .ctrl(ctrl), .sel(sel), .hold(hold),
    .hold_full(hold_full), .abort(abort), .miso(miso_i), .tick(tick),
    .busy(busy), .load(load), .done_evt(done_evt), .sck(sck_o),
    .mosi(mosi_o), .cs_n(cs_n_o), .rx_word(rx_word)
  );
endmodule

// File: rtl/spi_host_chk.sv
module spi_host_chk #(
  parameter int NSS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NSS-1:0] cs_n,
  input logic           sck,
  input logic           cpol,
  input logic           en,
  input logic           master,
  input logic           busy,
  input logic           modf,
  input logic           done,
  input logic           ss_low,
  input logic           ctrl_wr
);
  logic [NSS-1:0] cs_act;
  assign cs_act = ~cs_n;

  // R8
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cs_act) <= 1);

  // R3
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy) && $stable(cpol)) |-> (sck == cpol));

  // R11
  modf_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(modf) |-> $past(busy));

  // R9
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (&cs_n));

  // R2
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (&cs_n));

  // R12
  master_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(master) |-> ($past(ss_low) || $past(ctrl_wr)));
endmodule

bind spi_host_ctrl spi_host_chk #(.NSS(NSS)) u_chk (
  .clk(clk), .rst_n(rst_q), .cs_n(cs_n_o), .sck(sck_o), .cpol(ctrl.cpol),
  .en(ctrl.en), .master(ctrl.master), .busy(busy), .modf(modf_q),
  .done(done_q), .ss_low(ss_low), .ctrl_wr(reg_we && (reg_addr == 3'd0))
);

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_we;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        sck_o, mosi_o, miso_i, ss_in_n;
  logic [3:0]  cs_n_o;

  spi_host_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sck_o(sck_o),
    .mosi_o(mosi_o), .miso_i(miso_i), .ss_in_n(ss_in_n), .cs_n_o(cs_n_o)
  );

  always #10ns clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual cycle %0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // slave model
  logic [31:0] s_tx, s_rx;
  int   s_nb = 8, s_edges = 0, s_first = 0, s_second = 0, s_last = 0, cs_rise = 0;
  bit   s_cpha = 0, s_lsb = 0, s_act = 0;
  logic [31:0] s_log [0:3];
  int   n_log = 0;

  function automatic logic sbit(int k);
    return s_lsb ? s_tx[k] : s_tx[s_nb - 1 - k];
  endfunction

  always @(cs_n_o) begin
    if (rst_n === 1'b1 && cs_n_o !== 4'hF && !s_act) begin
      s_act = 1; s_edges = 0; s_rx = '0; miso_i = sbit(0);
    end else if (cs_n_o === 4'hF && s_act) begin
      s_act = 0; s_log[n_log % 4] = s_rx; n_log++; cs_rise = cyc;
    end
  end

  always @(sck_o) begin
    if (s_act) begin
      int k;
      bit lead;
      s_edges++;
      if (s_edges == 1) s_first = cyc;
      if (s_edges == 2) s_second = cyc;
      s_last = cyc;
      lead = (s_edges % 2) == 1;
      if (lead ^ s_cpha) begin
        k = (s_edges - 1) / 2;
        if (k < s_nb) s_rx[s_lsb ? k : s_nb - 1 - k] = mosi_o;
      end else begin
        k = s_cpha ? (s_edges - 1) / 2 : s_edges / 2;
        if (k < s_nb) miso_i = sbit(k);
      end
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1ns;
    d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] wmask(int nb);
    return (nb == 32) ? 32'hFFFF_FFFF : ((32'd1 << nb) - 1);
  endfunction

  task automatic wait_done();
    logic [31:0] st;
    st = '0;
    for (int i = 0; i < 5000 && !st[0]; i++) rd(3'd4, st);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(3'd0, v); chk("R1 ctrl", v, 0);
    rd(3'd4, v); chk("R1 status", v, 0);
    rd(3'd3, v); chk("R1 rx", v, 0);
    chk("R1 cs", 32'(cs_n_o), 32'hF);
    chk("R1 sck", 32'(sck_o), 0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    int base;
    base = n_log;
    wr(3'd3, 32'hA5);
    idle(30);
    chk("R2 cs with enable off", 32'(cs_n_o), 32'hF);
    rd(3'd4, v); chk("R2 hold flag, enable off", 32'(v[3]), 0);
    wr(3'd0, 32'h1);
    wr(3'd3, 32'h5A);
    idle(30);
    chk("R2 cs with master off", 32'(cs_n_o), 32'hF);
    wr(3'd0, 32'h3);
    idle(40);
    chk("R2 no late start", 32'(n_log - base), 0);
    chk("R2 cs after enabling", 32'(cs_n_o), 32'hF);
  endtask

  task automatic t_xfer(bit cpol, bit cpha, bit lsb, logic [1:0] wsel,
                        int dv, int sel, logic [31:0] tx, logic [31:0] srx);
    logic [31:0] v;
    int nb;
    nb = (wsel == 0) ? 8 : (wsel == 1) ? 16 : 32;
    s_nb = nb; s_cpha = cpha; s_lsb = lsb; s_tx = srx;
    wr(3'd1, dv);
    wr(3'd2, sel);
    wr(3'd0, {25'd0, wsel, lsb, cpha, cpol, 2'b11});
    idle(2);
    chk("R3 idle sck", 32'(sck_o), 32'(cpol));
    wr(3'd3, tx);
    for (int i = 0; i < 10 && cs_n_o == 4'hF; i++) idle(1);
    chk("R8 cs one-hot on selected line", 32'(cs_n_o), 32'(~(4'd1 << sel) & 4'hF));
    wait_done();
    idle(2);
    rd(3'd4, v); chk("R9 done flag", 32'(v[0]), 1);
    rd(3'd3, v);
    chk(lsb ? "R6 R7 rx word lsb-first" : "R5 R7 rx word msb-first", v, srx & wmask(nb));
    chk(lsb ? "R6 slave got lsb-first word" : "R5 slave got msb-first word",
        s_log[(n_log - 1) % 4], tx & wmask(nb));
    chk("R5 R7 edge count", 32'(s_edges), 32'(2 * nb));
    chk("R4 half period", 32'(s_second - s_first), 32'(dv + 1));
    chk("R8 release delay", 32'(cs_rise - s_last), 32'(dv + 1));
    chk("R3 sck back at idle", 32'(sck_o), 32'(cpol));
    wr(3'd4, 32'h1);
  endtask

  task automatic t_backtoback();
    logic [31:0] v;
    int base;
    s_nb = 8; s_cpha = 0; s_lsb = 0; s_tx = 32'h3C;
    wr(3'd1, 1);
    wr(3'd0, 32'h3);
    base = n_log;
    wr(3'd3, 32'hC1);
    for (int i = 0; i < 10 && cs_n_o == 4'hF; i++) idle(1);
    wr(3'd3, 32'h7E);
    rd(3'd4, v); chk("R10 holding full while busy", 32'(v[3]), 1);
    for (int i = 0; i < 2000 && n_log < base + 2; i++) idle(1);
    chk("R10 two words sent", 32'(n_log - base), 2);
    chk("R10 first word", s_log[base % 4], 32'hC1);
    chk("R10 second word", s_log[(base + 1) % 4], 32'h7E);
    idle(2);
    rd(3'd3, v); chk("R10 rx of second word", v, 32'h3C);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    rd(3'd4, v); chk("R13 done set before clear", 32'(v[0]), 1);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R13 write zero keeps done", 32'(v[0]), 1);
    wr(3'd4, 32'h1);
    rd(3'd4, v); chk("R13 write one clears done", 32'(v[0]), 0);
  endtask

  task automatic t_modf_busy();
    logic [31:0] v;
    s_nb = 32; s_cpha = 0; s_lsb = 0; s_tx = 32'h0;
    wr(3'd1, 9);
    wr(3'd0, 32'h43);
    wr(3'd3, 32'h1234_5678);
    idle(40);
    chk("R11 busy before contention", 32'(cs_n_o != 4'hF), 1);
    ss_in_n = 1'b0;
    idle(6);
    rd(3'd4, v);
    chk("R11 fault flag", 32'(v[1]), 1);
    chk("R11 no done", 32'(v[0]), 0);
    chk("R11 not busy", 32'(v[2]), 0);
    chk("R11 cs released", 32'(cs_n_o), 32'hF);
    rd(3'd0, v); chk("R11 master cleared", 32'(v[1]), 0);
    ss_in_n = 1'b1;
    idle(4);
    wr(3'd4, 32'h0);
    rd(3'd4, v); chk("R13 write zero keeps fault", 32'(v[1]), 1);
    wr(3'd4, 32'h2);
    rd(3'd4, v); chk("R13 fault cleared", 32'(v[1]), 0);
  endtask

  task automatic t_modf_idle();
    logic [31:0] v;
    wr(3'd0, 32'h3);
    idle(3);
    ss_in_n = 1'b0;
    idle(6);
    ss_in_n = 1'b1;
    idle(4);
    rd(3'd0, v); chk("R12 master cleared when idle", 32'(v[1]), 0);
    rd(3'd4, v); chk("R12 no fault flag when idle", 32'(v[1]), 0);
    chk("R12 cs idle", 32'(cs_n_o), 32'hF);
  endtask

  initial begin
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    miso_i = 1'b0; ss_in_n = 1'b1; s_tx = '0; s_rx = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_disabled();
    t_xfer(0, 0, 0, 2'd0, 1, 0, 32'hFFFF_FF93, 32'h5C);
    t_xfer(0, 1, 1, 2'd1, 2, 1, 32'h0000_BEEF, 32'h1234);
    t_xfer(1, 0, 0, 2'd2, 0, 2, 32'hDEAD_BEEF, 32'h0F1E_2D3C);
    t_xfer(1, 1, 1, 2'd0, 3, 3, 32'h81, 32'h6E);
    t_xfer(0, 0, 1, 2'd3, 1, 1, 32'hC0FF_EE01, 32'h8000_0001);
    t_backtoback();
    t_w1c();
    t_modf_busy();
    t_modf_idle();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule